// File: doc/BRIEF.md
# Pixel Rectangle Transfer Address Generator

This block turns rectangle transfer requests into pixel addresses for a frame store of 1024 columns by 512 rows of 16-bit pixels. A header names an operation, a start position and a size. For a host write or host read, each 32-bit data word then supplies or requests two pixels. The two pixels go out on two memory lanes, in raster order inside the rectangle, wrapping from the right edge of the rectangle to the next row. The host may deliver the words in bursts of any length with idle cycles in between. When the last pixel has been transferred, a one-cycle completion pulse is raised.

A third operation copies one rectangle to another inside the frame store with no host data. Lane A issues the source reads and lane B issues the destination writes one cycle later, using the data that the memory returns. A mask option forces the top bit of every pixel written. The memory itself sits outside the block. Every lane address is `{row[8:0], column[9:0]}`, which equals row*1024+column, and the memory returns read data one cycle after a lane A read.

Top module: `vram_rect_xfer`

## Requirements
- R1: The start column is `hdr_pos[9:0]` and the start row is `hdr_pos[24:16]`. Every lane address is `{row, column}`, so the first pixel of a transfer lands at exactly that column and row.
- R2: The width is `((hdr_size[9:0]-1) mod 1024)+1` and the height is `((hdr_size[24:16]-1) mod 512)+1`. An encoded 0 therefore means 1024 columns or 512 rows.
- R3: In a word accepted on `word_valid`, the low half is the earlier pixel and goes on lane A. The high half is the next pixel in raster order and goes on lane B. When the transfer has an odd pixel count, lane B stays idle on the final word.
- R4: Columns wrap modulo 1024 and rows wrap modulo 512 as the transfer advances from the start position.
- R5: When `mask_en` is high at header acceptance, bit 15 of every pixel written by that transfer is forced to 1. All other bits pass through unchanged.
- R6: Idle cycles between words do not disturb the transfer. The next word resumes at the saved column and row, including in the middle of a row.
- R7: Op code (`hdr_op`) 1 is a read. It drives `img_ready` high from the cycle after the header until the cycle after the last read word. Completing a write (op 0) or a copy (op 2) sets `fb_dirty`, which stays set until `dirty_ack` is asserted.
- R8: `done` is high for exactly one cycle, the cycle after the last pixel is issued, and `busy` is low from that same cycle.
- R9: A header accepted while a transfer is unfinished aborts the old transfer without completing it. A data word presented in the same cycle as the header is dropped.
- R10: In a copy, source and destination coordinates wrap modulo 1024 and 512. Each lane B write issues one cycle after its lane A read and carries the returned data, with bit 15 forced when the mask is set.
- R11: A copy whose source equals its destination, with `mask_en` low, touches no memory and pulses `done` in the next cycle.
- R12: A copy with source column < destination column < source column + width walks each row from right to left. Otherwise it walks left to right. Either way, every pixel is read before it can be overwritten.
- R13: While no transfer is active, data words produce no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header strobe |
| hdr_op | input | 2 | 0 write, 1 read, 2 copy, 3 abort only |
| hdr_pos | input | 32 | Start position (copy source) |
| hdr_size | input | 32 | Encoded width and height |
| hdr_dst | input | 32 | Copy destination position |
| mask_en | input | 1 | Force bit 15 on written pixels |
| word_valid | input | 1 | Host data word strobe |
| word_data | input | 32 | Two write pixels, low half first |
| a_en | output | 1 | Lane A access |
| a_we | output | 1 | Lane A write (else read) |
| a_addr | output | 19 | Lane A pixel address |
| a_wdata | output | 16 | Lane A write pixel |
| a_rdata | input | 16 | Lane A read data, one cycle after the read |
| b_en | output | 1 | Lane B access |
| b_we | output | 1 | Lane B write (else read) |
| b_addr | output | 19 | Lane B pixel address |
| b_wdata | output | 16 | Lane B write pixel |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| img_ready | output | 1 | Host read in progress |
| fb_dirty | output | 1 | Frame store modified |
| dirty_ack | input | 1 | Clears `fb_dirty` |

## Verification
The hardest situations to reach are the maximum sizes. They need an encoded zero width or height, and the bench drives full 1024-wide and 512-tall strips word by word until the final lane B pixel and the row wrap past 511 appear. The overlapping copy needs source and destination on the same row, a few columns apart, so the bench checks that each read address is issued in descending column order and that each write follows its read by one cycle. Mid-row resumption and abort are reached by stopping the word stream partway through a row, then either idling or sending a fresh header.

// File: rtl/vrt_pkg.sv
package vrt_pkg;
   typedef enum logic [1:0] {
      OP_WRITE = 2'd0,
      OP_READ  = 2'd1,
      OP_COPY  = 2'd2,
      OP_NONE  = 2'd3
   } vrt_op_e;
endpackage

// File: rtl/vrt_hdr_dec.sv
// Extracts start coordinates and decoded extent from a header pair (R1, R2).
module vrt_hdr_dec #(
   parameter int XW   = 10,
   parameter int YW   = 9,
   parameter int YOFS = 16
) (
   input  logic [31:0]   pos,
   input  logic [31:0]   size,
   output logic [XW-1:0] x,
   output logic [YW-1:0] y,
   output logic [XW:0]   w,
   output logic [YW:0]   h
);
   logic [XW-1:0] w_m1;
   logic [YW-1:0] h_m1;

   assign x    = pos[XW-1:0];
   assign y    = pos[YOFS +: YW];
   assign w_m1 = size[XW-1:0] - 1'b1;
   assign h_m1 = size[YOFS +: YW] - 1'b1;
   assign w    = {1'b0, w_m1} + 1'b1;
   assign h    = {1'b0, h_m1} + 1'b1;
endmodule

// File: rtl/vrt_walker.sv
// Host-word raster walker: two pixels per accepted word.
module vrt_walker #(
   parameter int XW = 10,
   parameter int YW = 9,
   parameter int PW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             kill,
   input  logic             rd_mode,
   input  logic             mask,
   input  logic [XW-1:0]    x0_i,
   input  logic [YW-1:0]    y0_i,
   input  logic [XW:0]      w_i,
   input  logic [YW:0]      h_i,
   input  logic             word_valid,
   input  logic [2*PW-1:0]  word_data,
   output logic             a_en,
   output logic             a_we,
   output logic [XW+YW-1:0] a_addr,
   output logic [PW-1:0]    a_wdata,
   output logic             b_en,
   output logic             b_we,
   output logic [XW+YW-1:0] b_addr,
   output logic [PW-1:0]    b_wdata,
   output logic             active,
   output logic             fin
);
   typedef struct packed {
      logic [XW:0]   off;
      logic [YW-1:0] y;
      logic [YW:0]   hl;
   } wpos_t;

   function automatic wpos_t step(wpos_t p, logic [XW:0] wid);
      wpos_t n;
      n = p;
      if (p.off == wid - 1'b1) begin
         n.off = '0;
         n.y   = p.y + 1'b1;
         n.hl  = p.hl - 1'b1;
      end else begin
         n.off = p.off + 1'b1;
      end
      return n;
   endfunction

   logic          act_q, rd_q, msk_q;
   logic [XW-1:0] x0_q;
   logic [XW:0]   w_q;
   wpos_t         cur_q, p1, p2;
   logic          fire;

   assign p1   = step(cur_q, w_q);
   assign p2   = step(p1, w_q);
   assign fire = act_q & word_valid & ~kill;
   assign fin  = fire & ((p1.hl == '0) | (p2.hl == '0));

   assign a_en    = fire;
   assign a_we    = ~rd_q;
   assign a_addr  = {cur_q.y, x0_q + cur_q.off[XW-1:0]};
   assign a_wdata = {word_data[PW-1] | msk_q, word_data[PW-2:0]};
   assign b_en    = fire & (p1.hl != '0);
   assign b_we    = ~rd_q;
   assign b_addr  = {p1.y, x0_q + p1.off[XW-1:0]};
   assign b_wdata = {word_data[2*PW-1] | msk_q, word_data[2*PW-2:PW]};
   assign active  = act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         rd_q  <= 1'b0;
         msk_q <= 1'b0;
         x0_q  <= '0;
         w_q   <= '0;
         cur_q <= '0;
      end else if (kill) begin
         act_q     <= start;
         rd_q      <= rd_mode;
         msk_q     <= mask & ~rd_mode;
         x0_q      <= x0_i;
         w_q       <= w_i;
         cur_q.off <= '0;
         cur_q.y   <= y0_i;
         cur_q.hl  <= h_i;
      end else if (fire) begin
         cur_q <= p2;
         if (fin) act_q <= 1'b0;
      end
   end
endmodule

// File: rtl/vrt_copier.sv
// Rectangle copy engine: read on lane A, write on lane B one cycle later.
module vrt_copier #(
   parameter int XW = 10,
   parameter int YW = 9,
   parameter int PW = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             kill,
   input  logic             mask,
   input  logic [XW-1:0]    sx_i,
   input  logic [YW-1:0]    sy_i,
   input  logic [XW-1:0]    dx_i,
   input  logic [YW-1:0]    dy_i,
   input  logic [XW:0]      w_i,
   input  logic [YW:0]      h_i,
   input  logic [PW-1:0]    rdata,
   output logic             a_en,
   output logic [XW+YW-1:0] a_addr,
   output logic             b_en,
   output logic [XW+YW-1:0] b_addr,
   output logic [PW-1:0]    b_wdata,
   output logic             active,
   output logic             fin
);
   localparam int AW = XW + YW;

   logic          rd_go_q, desc_q, msk_q;
   logic [XW-1:0] sx_q, dx_q;
   logic [YW-1:0] sy_q, dy_q;
   logic [XW:0]   w_q, col_q, xo_full;
   logic [YW:0]   h_q, row_q;
   logic          pv_q, plast_q;
   logic [AW-1:0] paddr_q, dst_addr;
   logic [XW-1:0] xo;
   logic          row_end, last_px, desc_in;

   assign xo_full  = desc_q ? (w_q - 1'b1 - col_q) : col_q;
   assign xo       = xo_full[XW-1:0];
   assign row_end  = (col_q == w_q - 1'b1);
   assign last_px  = row_end & (row_q == h_q - 1'b1);
   assign a_addr   = {sy_q + row_q[YW-1:0], sx_q + xo};
   assign dst_addr = {dy_q + row_q[YW-1:0], dx_q + xo};
   assign desc_in  = ({1'b0, sx_i} < {1'b0, dx_i}) && ({1'b0, dx_i} < ({1'b0, sx_i} + w_i));

   assign a_en    = rd_go_q & ~kill;
   assign b_en    = pv_q & ~kill;
   assign b_addr  = paddr_q;
   assign b_wdata = {rdata[PW-1] | msk_q, rdata[PW-2:0]};
   assign fin     = pv_q & plast_q & ~kill;
   assign active  = rd_go_q | pv_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_go_q <= 1'b0;
         desc_q  <= 1'b0;
         msk_q   <= 1'b0;
         sx_q    <= '0;
         sy_q    <= '0;
         dx_q    <= '0;
         dy_q    <= '0;
         w_q     <= '0;
         h_q     <= '0;
         col_q   <= '0;
         row_q   <= '0;
         pv_q    <= 1'b0;
         plast_q <= 1'b0;
         paddr_q <= '0;
      end else if (kill) begin
         rd_go_q <= start;
         desc_q  <= desc_in;
         msk_q   <= mask;
         sx_q    <= sx_i;
         sy_q    <= sy_i;
         dx_q    <= dx_i;
         dy_q    <= dy_i;
         w_q     <= w_i;
         h_q     <= h_i;
         col_q   <= '0;
         row_q   <= '0;
         pv_q    <= 1'b0;
      end else begin
         pv_q <= rd_go_q;
         if (rd_go_q) begin
            paddr_q <= dst_addr;
            plast_q <= last_px;
            if (last_px) rd_go_q <= 1'b0;
            if (row_end) begin
               col_q <= '0;
               row_q <= row_q + 1'b1;
            end else begin
               col_q <= col_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer #(
   parameter int XW      = 10,
   parameter int YW      = 9,
   parameter int PW      = 16,
   parameter int YOFS    = 16,
   parameter int COPY_EN = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hdr_valid,
   input  logic [1:0]       hdr_op,
   input  logic [31:0]      hdr_pos,
   input  logic [31:0]      hdr_size,
   input  logic [31:0]      hdr_dst,
   input  logic             mask_en,
   input  logic             word_valid,
   input  logic [2*PW-1:0]  word_data,
   output logic             a_en,
   output logic             a_we,
   output logic [XW+YW-1:0] a_addr,
   output logic [PW-1:0]    a_wdata,
   input  logic [PW-1:0]    a_rdata,
   output logic             b_en,
   output logic             b_we,
   output logic [XW+YW-1:0] b_addr,
   output logic [PW-1:0]    b_wdata,
   output logic             busy,
   output logic             done,
   output logic             img_ready,
   output logic             fb_dirty,
   input  logic             dirty_ack
);
   import vrt_pkg::*;
   localparam int AW = XW + YW;

   if (XW < 2 || XW > YOFS) begin : g_bad_xw
      $error("XW must lie in 2..YOFS");
   end
   if (YW < 1 || YOFS + YW > 32) begin : g_bad_yw
      $error("row field must fit in 32 bits");
   end
   if (PW < 2) begin : g_bad_pw
      $error("PW must be at least 2");
   end

   vrt_op_e       op;
   logic [XW-1:0] sx, dx;
   logic [YW-1:0] sy, dy;
   logic [XW:0]   w;
   logic [YW:0]   h;
   logic          same_pos, noop, wk_start, cp_start;

   vrt_hdr_dec #(.XW(XW), .YW(YW), .YOFS(YOFS)) u_dec (
      .pos(hdr_pos), .size(hdr_size), .x(sx), .y(sy), .w(w), .h(h)
   );

   assign op       = vrt_op_e'(hdr_op);
   assign dx       = hdr_dst[XW-1:0];
   assign dy       = hdr_dst[YOFS +: YW];
   assign same_pos = (sx == dx) && (sy == dy);
   assign noop     = (COPY_EN != 0) && (op == OP_COPY) && same_pos && !mask_en;
   assign wk_start = hdr_valid && (op == OP_WRITE || op == OP_READ);
   assign cp_start = hdr_valid && (op == OP_COPY) && !noop;

   logic          wk_a_en, wk_a_we, wk_b_en, wk_b_we, wk_act, wk_fin;
   logic [AW-1:0] wk_a_addr, wk_b_addr;
   logic [PW-1:0] wk_a_wdata, wk_b_wdata;

   vrt_walker #(.XW(XW), .YW(YW), .PW(PW)) u_walk (
      .clk(clk), .rst_n(rst_n), .start(wk_start), .kill(hdr_valid),
      .rd_mode(op == OP_READ), .mask(mask_en),
      .x0_i(sx), .y0_i(sy), .w_i(w), .h_i(h),
      .word_valid(word_valid), .word_data(word_data),
      .a_en(wk_a_en), .a_we(wk_a_we), .a_addr(wk_a_addr), .a_wdata(wk_a_wdata),
      .b_en(wk_b_en), .b_we(wk_b_we), .b_addr(wk_b_addr), .b_wdata(wk_b_wdata),
      .active(wk_act), .fin(wk_fin)
   );

   logic          cp_a_en, cp_b_en, cp_act, cp_fin;
   logic [AW-1:0] cp_a_addr, cp_b_addr;
   logic [PW-1:0] cp_b_wdata;

   if (COPY_EN != 0) begin : g_copy
      vrt_copier #(.XW(XW), .YW(YW), .PW(PW)) u_copy (
         .clk(clk), .rst_n(rst_n), .start(cp_start), .kill(hdr_valid),
         .mask(mask_en), .sx_i(sx), .sy_i(sy), .dx_i(dx), .dy_i(dy),
         .w_i(w), .h_i(h), .rdata(a_rdata),
         .a_en(cp_a_en), .a_addr(cp_a_addr),
         .b_en(cp_b_en), .b_addr(cp_b_addr), .b_wdata(cp_b_wdata),
         .active(cp_act), .fin(cp_fin)
      );
   end else begin : g_nocopy
      assign cp_a_en    = 1'b0;
      assign cp_a_addr  = '0;
      assign cp_b_en    = 1'b0;
      assign cp_b_addr  = '0;
      assign cp_b_wdata = '0;
      assign cp_act     = 1'b0;
      assign cp_fin     = 1'b0;
   end

   assign a_en    = wk_a_en | cp_a_en;
   assign a_we    = wk_a_en & wk_a_we;
   assign a_addr  = wk_a_en ? wk_a_addr : cp_a_addr;
   assign a_wdata = wk_a_wdata;
   assign b_en    = wk_b_en | cp_b_en;
   assign b_we    = wk_b_en ? wk_b_we : cp_b_en;
   assign b_addr  = wk_b_en ? wk_b_addr : cp_b_addr;
   assign b_wdata = wk_b_en ? wk_b_wdata : cp_b_wdata;
   assign busy    = wk_act | cp_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done      <= 1'b0;
         img_ready <= 1'b0;
         fb_dirty  <= 1'b0;
      end else begin
         done <= wk_fin | cp_fin | (hdr_valid & noop);
         if (hdr_valid)   img_ready <= wk_start & (op == OP_READ);
         else if (wk_fin) img_ready <= 1'b0;
         if ((wk_fin & ~img_ready) | cp_fin) fb_dirty <= 1'b1;
         else if (dirty_ack)                 fb_dirty <= 1'b0;
      end
   end
endmodule

// File: rtl/vram_rect_xfer_chk.sv
module vram_rect_xfer_chk #(
   parameter int AW = 19
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          done,
   input logic          img_ready,
   input logic          fb_dirty,
   input logic          a_en,
   input logic          a_we,
   input logic          b_en,
   input logic          b_we,
   input logic [AW-1:0] a_addr,
   input logic [AW-1:0] b_addr
);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R3
   lane_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (b_en && !(b_we && !a_we)) |-> a_en);

   // R3
   distinct_pixels_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && a_we && b_en && b_we) |-> (a_addr != b_addr));

   // R7
   read_flag_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      img_ready |-> busy);

   // R7
   dirty_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fb_dirty) |-> done);

   // R13
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!a_en && !b_en));
endmodule

bind vram_rect_xfer vram_rect_xfer_chk #(.AW(XW + YW)) u_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
   .img_ready(img_ready), .fb_dirty(fb_dirty),
   .a_en(a_en), .a_we(a_we), .b_en(b_en), .b_we(b_we),
   .a_addr(a_addr), .b_addr(b_addr)
);

// File: tb/vram_rect_xfer_test.sv
module vram_rect_xfer_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [1:0]  hdr_op = 2'd0;
   logic [31:0] hdr_pos = '0, hdr_size = '0, hdr_dst = '0;
   logic        mask_en = 1'b0;
   logic        word_valid = 1'b0;
   logic [31:0] word_data = '0;
   logic        a_en, a_we, b_en, b_we;
   logic [18:0] a_addr, b_addr;
   logic [15:0] a_wdata, b_wdata;
   logic [15:0] a_rdata = '0;
   logic        busy, done, img_ready, fb_dirty;
   logic        dirty_ack = 1'b0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vram_rect_xfer uut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_op(hdr_op),
      .hdr_pos(hdr_pos), .hdr_size(hdr_size), .hdr_dst(hdr_dst),
      .mask_en(mask_en), .word_valid(word_valid), .word_data(word_data),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(a_rdata), .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
      .b_wdata(b_wdata), .busy(busy), .done(done), .img_ready(img_ready),
      .fb_dirty(fb_dirty), .dirty_ack(dirty_ack)
   );

   function automatic logic [15:0] memf(logic [18:0] a);
      return a[15:0] ^ 16'h3C5A;
   endfunction

   // frame store model: read data one cycle after a lane A read
   always_ff @(posedge clk)
      if (a_en && !a_we) a_rdata <= memf(a_addr);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [18:0] paddr(int x0, int y0, int w, int k);
      int xe, ye;
      xe = (x0 + k % w) % 1024;
      ye = (y0 + k / w) % 512;
      return {ye[8:0], xe[9:0]};
   endfunction

   task automatic hdr(input logic [1:0] op, input int x, input int y, input int wenc,
                      input int henc, input int dxp, input int dyp, input logic m);
      @(negedge clk);
      hdr_valid = 1'b1;
      hdr_op    = op;
      hdr_pos   = {7'd0, 9'(y), 6'd0, 10'(x)};
      hdr_size  = {7'd0, 9'(henc), 6'd0, 10'(wenc)};
      hdr_dst   = {7'd0, 9'(dyp), 6'd0, 10'(dxp)};
      mask_en   = m;
      @(negedge clk);
      hdr_valid = 1'b0;
      mask_en   = 1'b0;
   endtask

   // sends words k0.., checks both lanes per word; returns in the cycle after the last edge
   task automatic words(input string req, input int x0, input int y0, input int w, input int h,
                        input int k0, input int nw, input bit rd, input bit m);
      for (int i = 0; i < nw; i++) begin
         int k;
         logic [15:0] lo, hi;
         k  = k0 + 2 * i;
         lo = 16'(16'h1000 + k);
         hi = 16'(16'h2000 + k);
         word_valid = 1'b1;
         word_data  = {hi, lo};
         #1;
         check({req, " lane A en"}, a_en, 1);
         check({req, " lane A we"}, a_we, !rd);
         check({req, " lane A addr"}, a_addr, paddr(x0, y0, w, k));
         if (!rd) check({req, " lane A data"}, a_wdata, lo | {m, 15'd0});
         if (k + 1 < w * h) begin
            check({req, " lane B addr"}, b_addr, paddr(x0, y0, w, k + 1));
            check({req, " lane B en"}, b_en, 1);
            if (!rd) check({req, " lane B data"}, b_wdata, hi | {m, 15'd0});
         end else begin
            check({req, " lane B idle on odd tail"}, b_en, 0);
         end
         @(negedge clk);
         word_valid = 1'b0;
      end
   endtask

   task automatic ack_dirty();
      @(negedge clk);
      dirty_ack = 1'b1;
      @(negedge clk);
      dirty_ack = 1'b0;
      #1;
      check("R7 dirty cleared by ack", fb_dirty, 0);
   endtask

   task automatic t_reset();
      #1;
      check("R8 reset busy", busy, 0);
      check("R8 reset done", done, 0);
      check("R7 reset img_ready", img_ready, 0);
      check("R7 reset fb_dirty", fb_dirty, 0);
      check("R13 reset lanes", {a_en, b_en}, 0);
   endtask

   task automatic t_write_basic();
      hdr(2'd0, 5, 3, 3, 2, 0, 0, 0);
      #1 check("R1 busy after header", busy, 1);
      words("R1 R3 write", 5, 3, 3, 2, 0, 3, 0, 0);
      #1;
      check("R8 done after last word", done, 1);
      check("R8 busy low at done", busy, 0);
      check("R7 write sets dirty", fb_dirty, 1);
      @(negedge clk); #1;
      check("R8 done lasts one cycle", done, 0);
      ack_dirty();
   endtask

   task automatic t_odd();
      hdr(2'd0, 40, 9, 3, 1, 0, 0, 0);
      words("R3 odd count", 40, 9, 3, 1, 0, 2, 0, 0);
      #1 check("R8 odd done", done, 1);
      ack_dirty();
   endtask

   task automatic t_mask();
      hdr(2'd0, 0, 0, 2, 1, 0, 0, 1);
      words("R5 mask", 0, 0, 2, 1, 0, 1, 0, 1);
      ack_dirty();
   endtask

   task automatic t_burst();
      hdr(2'd0, 100, 50, 3, 2, 0, 0, 0);
      words("R6 burst one", 100, 50, 3, 2, 0, 1, 0, 0);
      for (int i = 0; i < 3; i++) begin
         #1 check("R6 no access in gap", {a_en, b_en}, 0);
         @(negedge clk);
      end
      words("R6 resume mid-row", 100, 50, 3, 2, 2, 2, 0, 0);
      #1 check("R6 done after resume", done, 1);
      ack_dirty();
   endtask

   task automatic t_wrap();
      hdr(2'd0, 1022, 511, 4, 2, 0, 0, 0);
      words("R4 wrap", 1022, 511, 4, 2, 0, 4, 0, 0);
      #1 check("R4 wrap done", done, 1);
      ack_dirty();
   endtask

   task automatic t_max();
      hdr(2'd0, 0, 7, 0, 1, 0, 0, 0);
      words("R2 width zero means 1024", 0, 7, 1024, 1, 0, 512, 0, 0);
      #1 check("R2 width 1024 done", done, 1);
      ack_dirty();
      hdr(2'd0, 3, 0, 1, 0, 0, 0, 0);
      words("R2 height zero means 512", 3, 0, 1, 512, 0, 256, 0, 0);
      #1 check("R2 height 512 done", done, 1);
      ack_dirty();
   endtask

   task automatic t_read();
      hdr(2'd1, 8, 2, 2, 2, 0, 0, 0);
      #1 check("R7 img_ready set", img_ready, 1);
      words("R7 read", 8, 2, 2, 2, 0, 2, 1, 0);
      #1;
      check("R7 img_ready cleared", img_ready, 0);
      check("R8 read done", done, 1);
      check("R7 read leaves dirty clear", fb_dirty, 0);
   endtask

   task automatic t_abort();
      hdr(2'd0, 0, 0, 4, 4, 0, 0, 0);
      words("R9 before abort", 0, 0, 4, 4, 0, 1, 0, 0);
      hdr(2'd0, 50, 7, 2, 1, 0, 0, 0);
      #1 check("R9 abort no done", done, 0);
      check("R9 abort no dirty", fb_dirty, 0);
      words("R9 new transfer", 50, 7, 2, 1, 0, 1, 0, 0);
      #1 check("R9 new transfer done", done, 1);
      ack_dirty();
   endtask

   task automatic t_idle();
      @(negedge clk);
      word_valid = 1'b1;
      word_data  = 32'hFFFF_FFFF;
      #1 check("R13 idle word no access", {a_en, b_en}, 0);
      @(negedge clk);
      word_valid = 1'b0;
      #1 check("R13 idle stays idle", {busy, done}, 0);
   endtask

   task automatic copy_run(input string req, input int sx, input int sy, input int dx,
                           input int dy, input int w, input int h, input bit m, input bit desc);
      int n;
      n = w * h;
      hdr(2'd2, sx, sy, w, h, dx, dy, m);
      for (int i = 0; i <= n; i++) begin
         #1;
         if (i < n) begin
            int c, xo;
            c  = i % w;
            xo = desc ? (w - 1 - c) : c;
            check({req, " read en"}, {a_en, a_we}, 2'b10);
            check({req, " read addr"}, a_addr, paddr(sx + xo, sy + i / w, 1024, 0));
         end else begin
            check({req, " read stops"}, a_en, 0);
         end
         if (i >= 1) begin
            int j, c, xo;
            j  = i - 1;
            c  = j % w;
            xo = desc ? (w - 1 - c) : c;
            check({req, " write en"}, {b_en, b_we}, 2'b11);
            check({req, " write addr"}, b_addr, paddr(dx + xo, dy + j / w, 1024, 0));
            check({req, " write data"}, b_wdata,
                  memf(paddr(sx + xo, sy + j / w, 1024, 0)) | {m, 15'd0});
         end else begin
            check({req, " no write yet"}, b_en, 0);
         end
         @(negedge clk);
      end
      #1;
      check({req, " done"}, done, 1);
      check({req, " busy low"}, busy, 0);
      check("R7 copy sets dirty", fb_dirty, 1);
      ack_dirty();
   endtask

   task automatic t_noop();
      hdr(2'd2, 30, 30, 5, 5, 30, 30, 0);
      #1;
      check("R11 noop done", done, 1);
      check("R11 noop no busy", busy, 0);
      check("R11 noop no access", {a_en, b_en}, 0);
      check("R11 noop no dirty", fb_dirty, 0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_write_basic();
      t_odd();
      t_mask();
      t_burst();
      t_wrap();
      t_max();
      t_read();
      t_abort();
      t_idle();
      copy_run("R10 copy wrap", 1022, 511, 3, 0, 3, 2, 1, 0);
      copy_run("R12 overlap descending", 10, 5, 12, 5, 4, 1, 0, 1);
      copy_run("R12 left shift ascending", 12, 5, 10, 5, 4, 1, 0, 0);
      t_noop();
      finish_run();
   end
endmodule